// File: doc/BRIEF.md
# Ping-Pong Piecewise Gamma Curve

This block maps each colour channel of a pixel stream through a piecewise-linear transfer curve. The curve has 32 uniform segments per channel. Each segment holds a base value and a slope delta, and the output is the base plus the delta scaled by the pixel's position inside the segment. Two banks of curve storage exist side by side. Software loads a new curve into the bank that is not live while the other bank keeps driving pixels. It then names the new bank in the mode register, and the swap takes effect at the next frame-start pulse.

Loading goes through a small register port. A control register selects the target bank and a per-channel write mask. An index register sets the starting point. A single data register takes six writes per point, in the order red base, green base, blue base, red delta, green delta, blue delta, and then moves to the next point by itself. A power register must bring the curve memory out of power-down before any data write is accepted. A status output reports which bank is actually live.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: The mode register (address 3, bits [1:0]) uses 0 = bypass, 1 = bank A and 2 = bank B. Value 3 is taken as bypass. `live_status` reports the live selection with the same codes and never shows 3.
- R2: A mode write changes neither `live_status` nor the pixel path until the next `frame_start` pulse. `live_status` takes the new value on the clock edge that samples that pulse.
- R3: Control register (address 0): bit 0 picks the bank being loaded (0 = A, 1 = B). Bits [3:1] are a write mask with bit 1 for red, bit 2 for green and bit 3 for blue. A data write lands only in a channel whose mask bit is set, and the six-write sequence still advances for masked channels.
- R4: A write to the index register (address 1, bits [4:0]) sets the point index and restarts the six-write sequence. Data writes (address 2, bits [11:0]) fill red, green and blue base, then red, green and blue delta, and the index then advances by one.
- R5: The load index saturates at point 31. Further complete points overwrite point 31 and leave point 30 untouched.
- R6: While the power register (address 4, bit 0) is 0, which is its reset value, data writes are ignored. They change no stored value and do not advance the sequence.
- R7: In bank mode, with segment s = pix[9:5] and fraction f = pix[4:0], each channel outputs min(base[s] + ((delta[s]·f) >> 5), 4095). `out_valid` and the outputs are updated one clock after `pix_valid`.
- R8: In bypass, each 12-bit output equals the 10-bit input shifted left by two, with the same one-cycle latency.
- R9: Loading the bank that is not live leaves the live curve's output unchanged.
- R10: After reset, `out_valid` is 0, all outputs are 0, `live_status` is 0 (bypass) and the memory is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| frame_start | input | 1 | Frame-start pulse; applies a pending bank change |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | 10 | Red input |
| pix_g | input | 10 | Green input |
| pix_b | input | 10 | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Red output |
| out_g | output | 12 | Green output |
| out_b | output | 12 | Blue output |
| live_status | output | 2 | Live selection: 0 bypass, 1 bank A, 2 bank B |

## Verification
A pixel presented with `pix_valid` at one rising edge appears on the outputs after that edge. The bench drives inputs on the falling edge and reads the result at the next falling edge, one cycle later. A register write also takes effect at the first rising edge, so every load is complete before the pixels that depend on it are sent. `live_status` changes on the edge that samples `frame_start`. The bench checks it once just before the pulse, to confirm the old value holds, and once at the falling edge after the pulse, to confirm the new value.

// File: rtl/glut_pkg.sv
// Shared definitions for the ping-pong gamma curve block.
// Assumes the register address map below is fixed for all instances.
package glut_pkg;

    // Live selection codes, also driven on the status output.
    typedef enum logic [1:0] {
        LIVE_BYPASS = 2'd0,
        LIVE_A      = 2'd1,
        LIVE_B      = 2'd2
    } live_e;

    // Register addresses.
    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_INDEX = 3'd1;
    localparam logic [2:0] ADDR_DATA  = 3'd2;
    localparam logic [2:0] ADDR_MODE  = 3'd3;
    localparam logic [2:0] ADDR_POWER = 3'd4;

    // Number of data writes per curve point.
    localparam int WRITES_PER_POINT = 6;

endpackage

// File: rtl/glut_cfg.sv
// Register file and load sequencer.
// Holds the control, mode and power registers. Turns the stream of data
// writes into per-channel base and delta writes. Applies a mode change to
// the live selection only on a frame-start pulse.
// Assumes only one register write per cycle and CFG_W >= VAL_W.
module glut_cfg
    import glut_pkg::*;
#(
    parameter int SEG_BITS = 5,
    parameter int VAL_W    = 12,
    parameter int CFG_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                frame_start,
    output logic [2:0]          wr_en,
    output logic                wr_bank,
    output logic [SEG_BITS-1:0] wr_idx,
    output logic                wr_is_delta,
    output logic [VAL_W-1:0]    wr_val,
    output live_e               live
);

    localparam int                  NSEG     = 1 << SEG_BITS;
    localparam logic [SEG_BITS-1:0] LAST_IDX = SEG_BITS'(NSEG - 1);
    localparam logic [2:0]          LAST_PH  = 3'(WRITES_PER_POINT - 1);

    logic                ram_sel;
    logic [2:0]          wmask;
    logic                pwr_on;
    logic [1:0]          mode_q;
    logic [SEG_BITS-1:0] idx_q;
    logic [2:0]          phase_q;
    logic                data_acc;
    logic [1:0]          ch_sel;

    // Data write accepted only when memory is powered.
    assign data_acc = cfg_we && (cfg_addr == ADDR_DATA) && pwr_on;

    // Channel addressed by the current phase: 0..2 base, 3..5 delta.
    always_comb begin
        if (phase_q >= 3'd3) ch_sel = 2'(phase_q - 3'd3);
        else                 ch_sel = phase_q[1:0];
    end

    // Control, mode and power registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_sel <= 1'b0;
            wmask   <= 3'b000;
            pwr_on  <= 1'b0;
            mode_q  <= 2'd0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_CTRL: begin
                    ram_sel <= cfg_wdata[0];
                    wmask   <= cfg_wdata[3:1];
                end
                ADDR_MODE:  mode_q <= cfg_wdata[1:0];
                ADDR_POWER: pwr_on <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    // Load pointer: index and phase within the six-write point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            phase_q <= 3'd0;
        end else if (cfg_we && cfg_addr == ADDR_INDEX) begin
            idx_q   <= cfg_wdata[SEG_BITS-1:0];
            phase_q <= 3'd0;
        end else if (data_acc) begin
            if (phase_q == LAST_PH) begin
                phase_q <= 3'd0;
                if (idx_q != LAST_IDX) idx_q <= idx_q + 1'b1;
            end else begin
                phase_q <= phase_q + 3'd1;
            end
        end
    end

    // Live selection: decode mode, apply on frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= LIVE_BYPASS;
        end else if (frame_start) begin
            case (mode_q)
                2'd1:    live <= LIVE_A;
                2'd2:    live <= LIVE_B;
                default: live <= LIVE_BYPASS;
            endcase
        end
    end

    // Per-channel write enables from mask and phase.
    for (genvar c = 0; c < 3; c++) begin : g_wen
        assign wr_en[c] = data_acc && wmask[c] && (ch_sel == 2'(c));
    end

    assign wr_bank     = ram_sel;
    assign wr_idx      = idx_q;
    assign wr_is_delta = (phase_q >= 3'd3);
    assign wr_val      = cfg_wdata[VAL_W-1:0];

    // R1: live selection never holds the unused code.
    a_r1_live_legal: assert property (@(posedge clk) disable iff (!rst_n)
        live != 2'd3);

    // R2: live selection only moves on a frame-start pulse.
    a_r2_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(live));

    // R3: at most one channel written per data write.
    a_r3_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R4: phase stays within the six writes of a point.
    a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < 3'(WRITES_PER_POINT));

    // R4: index advances by one after the last write of a point.
    a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && phase_q == LAST_PH && idx_q != LAST_IDX)
        |=> idx_q == $past(idx_q) + 1'b1);

    // R5: index saturates at the last point.
    a_r5_idx_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && idx_q == LAST_IDX) |=> idx_q == LAST_IDX);

    // R6: no channel write while the memory is powered down.
    a_r6_no_write_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> wr_en == 3'b000);

endmodule

// File: rtl/glut_store.sv
// Curve storage for one colour channel: two banks of base and delta tables.
// One write port loads either bank. One read port serves the live bank.
// Assumes the read address is stable during the pixel's cycle.
module glut_store #(
    parameter int SEG_BITS = 5,
    parameter int VAL_W    = 12
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic                wr_bank,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  logic                wr_is_delta,
    input  logic [VAL_W-1:0]    wr_val,
    input  logic                rd_bank,
    input  logic [SEG_BITS-1:0] rd_idx,
    output logic [VAL_W-1:0]    rd_base,
    output logic [VAL_W-1:0]    rd_delta
);

    localparam int NSEG = 1 << SEG_BITS;

    logic [VAL_W-1:0] bank_base  [2];
    logic [VAL_W-1:0] bank_delta [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [VAL_W-1:0] base_mem  [NSEG];
        logic [VAL_W-1:0] delta_mem [NSEG];

        // Write one table entry of this bank.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                if (wr_is_delta) delta_mem[wr_idx] <= wr_val;
                else             base_mem[wr_idx]  <= wr_val;
            end
        end

        assign bank_base[b]  = base_mem[rd_idx];
        assign bank_delta[b] = delta_mem[rd_idx];
    end

    assign rd_base  = bank_base[rd_bank];
    assign rd_delta = bank_delta[rd_bank];

endmodule

// File: rtl/glut_interp.sv
// Linear interpolation inside one segment for one channel.
// Splits the pixel into a segment index and a fraction, then forms
// base + (delta * frac) >> FRAC_W and saturates to the output width.
// Assumes PIX_W > SEG_BITS.
module glut_interp #(
    parameter int PIX_W    = 10,
    parameter int SEG_BITS = 5,
    parameter int VAL_W    = 12
) (
    input  logic [PIX_W-1:0]    pix,
    input  logic [VAL_W-1:0]    base,
    input  logic [VAL_W-1:0]    delta,
    output logic [SEG_BITS-1:0] seg,
    output logic [VAL_W-1:0]    result
);

    localparam int FRAC_W = PIX_W - SEG_BITS;
    localparam int PROD_W = VAL_W + FRAC_W;

    logic [FRAC_W-1:0] frac;
    logic [PROD_W-1:0] prod;
    logic [VAL_W:0]    sum;

    assign seg  = pix[PIX_W-1:FRAC_W];
    assign frac = pix[FRAC_W-1:0];

    // Scale the delta, add it to the base and clip.
    always_comb begin
        prod = PROD_W'(delta) * PROD_W'(frac);
        sum  = (VAL_W+1)'(base) + (VAL_W+1)'(prod >> FRAC_W);
        if (sum[VAL_W]) result = '1;
        else            result = sum[VAL_W-1:0];
    end

endmodule

// File: rtl/gamma_pingpong_lut.sv
// Top of the ping-pong gamma curve block.
// Three channels share one register file and load sequencer. Each channel
// has its own two-bank storage and interpolator. The output stage registers
// one result per valid pixel.
// Assumes VAL_W >= PIX_W and CFG_W >= VAL_W.
module gamma_pingpong_lut
    import glut_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int SEG_BITS = 5,
    parameter int VAL_W    = 12,
    parameter int CFG_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_r,
    input  logic [PIX_W-1:0] pix_g,
    input  logic [PIX_W-1:0] pix_b,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_r,
    output logic [VAL_W-1:0] out_g,
    output logic [VAL_W-1:0] out_b,
    output logic [1:0]       live_status
);

    localparam int BYP_SHIFT = VAL_W - PIX_W;

    logic [2:0]          wr_en;
    logic                wr_bank;
    logic [SEG_BITS-1:0] wr_idx;
    logic                wr_is_delta;
    logic [VAL_W-1:0]    wr_val;
    live_e               live;

    logic [PIX_W-1:0]    ch_pix  [3];
    logic [VAL_W-1:0]    ch_res  [3];
    logic [VAL_W-1:0]    ch_out  [3];

    assign ch_pix[0] = pix_r;
    assign ch_pix[1] = pix_g;
    assign ch_pix[2] = pix_b;

    glut_cfg #(
        .SEG_BITS (SEG_BITS),
        .VAL_W    (VAL_W),
        .CFG_W    (CFG_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .frame_start (frame_start),
        .wr_en       (wr_en),
        .wr_bank     (wr_bank),
        .wr_idx      (wr_idx),
        .wr_is_delta (wr_is_delta),
        .wr_val      (wr_val),
        .live        (live)
    );

    for (genvar c = 0; c < 3; c++) begin : g_ch
        logic [SEG_BITS-1:0] seg;
        logic [VAL_W-1:0]    base;
        logic [VAL_W-1:0]    delta;

        glut_store #(
            .SEG_BITS (SEG_BITS),
            .VAL_W    (VAL_W)
        ) u_store (
            .clk         (clk),
            .wr_en       (wr_en[c]),
            .wr_bank     (wr_bank),
            .wr_idx      (wr_idx),
            .wr_is_delta (wr_is_delta),
            .wr_val      (wr_val),
            .rd_bank     (live == LIVE_B),
            .rd_idx      (seg),
            .rd_base     (base),
            .rd_delta    (delta)
        );

        glut_interp #(
            .PIX_W    (PIX_W),
            .SEG_BITS (SEG_BITS),
            .VAL_W    (VAL_W)
        ) u_interp (
            .pix    (ch_pix[c]),
            .base   (base),
            .delta  (delta),
            .seg    (seg),
            .result (ch_res[c])
        );

        // Output register: curve result or shifted bypass value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_out[c] <= '0;
            end else if (pix_valid) begin
                if (live == LIVE_BYPASS) ch_out[c] <= VAL_W'(ch_pix[c]) << BYP_SHIFT;
                else                     ch_out[c] <= ch_res[c];
            end
        end
    end

    // Valid flag follows the input by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= pix_valid;
    end

    assign out_r       = ch_out[0];
    assign out_g       = ch_out[1];
    assign out_b       = ch_out[2];
    assign live_status = live;

    // R7: output valid one cycle after input valid.
    a_r7_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    // R7: no output valid without an input pixel.
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R8: bypass passes the red input shifted to the output width.
    a_r8_bypass_red: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && live == LIVE_BYPASS)
        |=> out_r == (VAL_W'($past(pix_r)) << BYP_SHIFT));

    // R7: outputs hold while no pixel arrives.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> $stable(out_g));

endmodule

// File: tb/tb_gamma_pingpong_lut.sv
module tb_gamma_pingpong_lut;

    localparam int CLK_PERIOD = 10;
    localparam int NPIX = 6;
    localparam logic [29:0] PIX_TAB [NPIX] = '{
        {10'd0,    10'd0,    10'd0},
        {10'd31,   10'd32,   10'd33},
        {10'd100,  10'd517,  10'd999},
        {10'd1023, 10'd1023, 10'd1023},
        {10'd640,  10'd5,    10'd800},
        {10'd255,  10'd256,  10'd257}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [9:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_valid;
    logic [11:0] out_r, out_g, out_b;
    logic [1:0]  live_status;

    int errors = 0;
    int checks = 0;
    int sb [2][3][32];
    int sd [2][3][32];

    gamma_pingpong_lut dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .live_status(live_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_point(input int r, input int g, input int b,
                            input int dr, input int dg, input int db);
        wr(3'd2, r); wr(3'd2, g); wr(3'd2, b);
        wr(3'd2, dr); wr(3'd2, dg); wr(3'd2, db);
    endtask

    task automatic frame();
        @(negedge clk); frame_start = 1'b1;
        @(posedge clk);
        @(negedge clk); frame_start = 1'b0;
    endtask

    // Expected channel value: bank -1 means bypass.
    function automatic int model(input int bank, input int ch, input int p);
        int s, f, v;
        if (bank < 0) return p * 4;
        s = p / 32; f = p % 32;
        v = sb[bank][ch][s] + ((sd[bank][ch][s] * f) / 32);
        return (v > 4095) ? 4095 : v;
    endfunction

    task automatic pix(input string tag, input int bank,
                       input int r, input int g, input int b);
        @(negedge clk);
        pix_valid = 1'b1; pix_r = 10'(r); pix_g = 10'(g); pix_b = 10'(b);
        @(posedge clk);
        @(negedge clk);
        pix_valid = 1'b0;
        check({tag, " valid"}, int'(out_valid), 1);
        check({tag, " red"},   int'(out_r), model(bank, 0, r));
        check({tag, " green"}, int'(out_g), model(bank, 1, g));
        check({tag, " blue"},  int'(out_b), model(bank, 2, b));
    endtask

    task automatic load_bank(input int bank);
        int k;
        wr(3'd0, (7 << 1) | bank);
        wr(3'd1, 0);
        for (int i = 0; i < 32; i++) begin
            for (int c = 0; c < 3; c++) begin
                k = 64 + 8 * c + 16 * bank;
                sb[bank][c][i] = i * k;
                sd[bank][c][i] = k + i;
            end
            wr_point(sb[bank][0][i], sb[bank][1][i], sb[bank][2][i],
                     sd[bank][0][i], sd[bank][1][i], sd[bank][2][i]);
        end
    endtask

    task automatic run_table(input string tag, input int bank);
        for (int i = 0; i < NPIX; i++)
            pix(tag, bank, int'(PIX_TAB[i][29:20]), int'(PIX_TAB[i][19:10]),
                int'(PIX_TAB[i][9:0]));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state.
        check("R10 out_valid", int'(out_valid), 0);
        check("R10 out_r", int'(out_r), 0);
        check("R10 status", int'(live_status), 0);
        // R10: memory starts powered down, so a data write is dropped and
        // the later full load still starts at point 0.
        wr(3'd0, 14);
        wr(3'd2, 4000);
        // R8: bypass after reset.
        run_table("R8 bypass", -1);

        // Load bank A while bypass is live.
        wr(3'd4, 1);
        load_bank(0);
        check("R2 status before mode", int'(live_status), 0);
        wr(3'd3, 1);
        // R2: no change until frame start.
        check("R2 status pending", int'(live_status), 0);
        pix("R2 still bypass", -1, 300, 400, 500);
        frame();
        check("R1 status bank A", int'(live_status), 1);
        run_table("R7 bank A", 0);

        // R9: load bank B while A is live.
        load_bank(1);
        run_table("R9 A unaffected", 0);
        wr(3'd3, 2);
        frame();
        check("R1 status bank B", int'(live_status), 2);
        run_table("R7 bank B", 1);

        // R1: code 3 is bypass.
        wr(3'd3, 3);
        frame();
        check("R1 code3 status", int'(live_status), 0);
        pix("R1 code3 bypass", -1, 1, 512, 1023);

        // R3: green-only mask into bank A, point 5.
        wr(3'd0, (3'b010 << 1) | 0);
        wr(3'd1, 5);
        wr_point(111, 222, 333, 11, 22, 33);
        sb[0][1][5] = 222; sd[0][1][5] = 22;
        // R3: masked phases still advance, so point 6 takes the next writes.
        wr_point(1, 777, 1, 1, 9, 1);
        sb[0][1][6] = 777; sd[0][1][6] = 9;
        wr(3'd3, 1);
        frame();
        pix("R3 mask point5", 0, 176, 176, 176);
        pix("R3 mask point6", 0, 200, 200, 200);

        // R6: writes ignored while powered down.
        wr(3'd4, 0);
        wr(3'd0, 14);
        wr(3'd1, 7);
        wr_point(999, 999, 999, 999, 999, 999);
        wr(3'd4, 1);
        pix("R6 unpowered ignored", 0, 232, 232, 232);

        // R5: saturation at point 31; R7 output clip.
        wr(3'd1, 30);
        wr_point(500, 600, 700, 5, 6, 7);
        wr_point(1, 2, 3, 0, 0, 0);
        wr_point(4000, 10, 20, 4000, 0, 0);
        sb[0][0][30] = 500; sb[0][1][30] = 600; sb[0][2][30] = 700;
        sd[0][0][30] = 5;   sd[0][1][30] = 6;   sd[0][2][30] = 7;
        sb[0][0][31] = 4000; sb[0][1][31] = 10; sb[0][2][31] = 20;
        sd[0][0][31] = 4000; sd[0][1][31] = 0;  sd[0][2][31] = 0;
        pix("R5 point30 kept", 0, 991, 991, 991);
        pix("R5 point31 overwritten", 0, 1000, 1000, 1000);
        pix("R7 saturation", 0, 1023, 1023, 1023);
        check("R7 clip value", int'(out_r), 4095);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule